// File: doc/BRIEF.md
# Multi-Target Serial Control Master

This block is a host-side command engine. It pushes configuration words to six peripheral chips over one shared serial clock and data line pair. A request carries a target code and a payload. The engine then builds the frame that target expects: its length, its clock rate, and either an active-low select held across the frame or a latch pulse after it. Two targets need more than a write. The decoder target shifts back a 24-bit word on a data-in line during the write, and the engine returns that word. The DSP target raises a host-request line while it takes a word, and the engine shows that line and reports when it stays silent.

The clock idles high. Data leaves MSB first, changes on the falling edge and is sampled on the rising edge. The rising edge also samples the data-in line. Two parameters set the half-period of the serial clock, in system-clock cycles: one for the slow group of targets and one for the fast group. A request is taken only while `busy` is low. `busy` stays high until the frame, any latch pulse and the guard gap have all finished.

Top module: `ser_ctl_master`

## Requirements
- R1: After reset and while idle, `sclk` is 1, all `sel_n` bits are 1, both `lat` bits are 0 and `busy` is 0.
- R2: Target code 0 (receiver) and code 1 (DAC) drive `sel_n[0]` and `sel_n[1]` low respectively for the whole frame. The frame is 24 bits: an address byte first (0x17 for code 0, 0x20 for code 1), then `req_data[15:0]`. The slow half-period is used.
- R3: Target code 2 (LED driver) sends `req_data[15:0]` as 16 bits at the slow rate with no select. After the last bit, `lat[0]` pulses high for two slow half-periods.
- R4: Target code 3 (IR transmitter) sends `req_data[23:0]` as 24 bits at the slow rate with no select. After the last bit, `lat[1]` pulses high for two slow half-periods.
- R5: Target code 4 (decoder) sends 24 bits under `sel_n[2]` at the fast rate. It captures `sdi` on each rising edge, MSB first, into `rd_data`. `rd_valid` pulses for one cycle when the select is released.
- R6: Target code 5 (DSP) sends 24 bits under `sel_n[3]` at the fast rate. `dsp_hreq` is `dsp_hreq_in` delayed by one clock. When the select is released, `hs_err` is set if the host-request line was never seen high during the frame, and cleared otherwise. It holds that value until the next accepted request.
- R7: Bits go out MSB first. Each low phase and each high phase of `sclk` lasts exactly the half-period of the selected rate. `sdo` is stable while `sclk` is high, and selects move only while `sclk` is high.
- R8: An accepted request keeps `busy` high for H·(2N+2) + 2H cycles, plus 2H when the target uses a latch pulse. H is the half-period and N the frame length. This includes a gap of at least one full serial period after the select or latch is released.
- R9: A request made while `busy` is high is refused and leaves the current frame unchanged.
- R10: Target codes 6 and 7 are ignored: `busy` stays low and the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_tgt | input | 3 | Target code 0..5 |
| req_data | input | 24 | Payload |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Shared serial clock, idles high |
| sdo | output | 1 | Shared serial data out |
| sdi | input | 1 | Serial data in from the decoder |
| sel_n | output | 4 | Active-low selects: receiver, DAC, decoder, DSP |
| lat | output | 2 | Latch pulses: LED driver, IR transmitter |
| dsp_hreq_in | input | 1 | Host-request line from the DSP |
| dsp_hreq | output | 1 | Registered host-request line |
| hs_err | output | 1 | Missing-handshake flag of the last DSP frame |
| rd_data | output | 24 | Word read back from the decoder |
| rd_valid | output | 1 | One-cycle strobe for rd_data |

## Verification
Every result has a fixed cycle count from the accepting edge. The busy window is H·(2N+2)+2H cycles, plus 2H for latch targets. The sclk low time totals N·H cycles. The latch pulse is 2H wide. `rd_data`, `rd_valid` and `hs_err` settle on the edge that releases the select, and `dsp_hreq` follows its input one edge later. The bench counts these durations on falling clock edges, away from the edges where the design updates. It compares them with the closed-form counts only after `busy` has dropped. It reads frame contents from `sdo` on each rising `sclk` edge, where the target would sample.

// File: rtl/ser_ctl_master.sv
module ser_ctl_master #(
  parameter int SLOW_HALF = 125,
  parameter int FAST_HALF = 62,
  parameter logic [7:0] ADDR_RX  = 8'h17,
  parameter logic [7:0] ADDR_DAC = 8'h20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_tgt,
  input  logic [23:0] req_data,
  output logic        busy,
  output logic        sclk,
  output logic        sdo,
  input  logic        sdi,
  output logic [3:0]  sel_n,
  output logic [1:0]  lat,
  input  logic        dsp_hreq_in,
  output logic        dsp_hreq,
  output logic        hs_err,
  output logic [23:0] rd_data,
  output logic        rd_valid
);
  localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int CW = $clog2(2 * MAXH + 1) + 1;
  localparam logic [2:0] T_RX = 3'd0, T_DAC = 3'd1, T_LED = 3'd2,
                         T_IR = 3'd3, T_DEC = 3'd4, T_DSP = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH, S_TAIL, S_LATCH, S_GAP} st_t;

  st_t st;
  logic [2:0]    tgt;
  logic [CW-1:0] half, cnt, lim;
  logic [4:0]    bitn, nb;
  logic [23:0]   sh, rx, frame;
  logic [3:0]    sel_of;
  logic          seen, accept, tick;

  assign busy   = st != S_IDLE;
  assign sdo    = sh[23];
  assign accept = req_valid && !busy && req_tgt <= T_DSP;
  assign lim    = (st == S_LATCH || st == S_GAP) ? {half[CW-2:0], 1'b0} - CW'(1) : half - CW'(1);
  assign tick   = cnt == lim;

  always_comb begin
    case (req_tgt)
      T_RX:    frame = {ADDR_RX, req_data[15:0]};
      T_DAC:   frame = {ADDR_DAC, req_data[15:0]};
      T_LED:   frame = {req_data[15:0], 8'h00};
      default: frame = req_data;
    endcase
    case (req_tgt)
      T_RX:    sel_of = 4'b1110;
      T_DAC:   sel_of = 4'b1101;
      T_DEC:   sel_of = 4'b1011;
      T_DSP:   sel_of = 4'b0111;
      default: sel_of = 4'b1111;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tgt <= '0; half <= '0; cnt <= '0; bitn <= '0; nb <= '0;
      sh <= '0; rx <= '0; seen <= 1'b0; sclk <= 1'b1; sel_n <= 4'hF; lat <= 2'b00;
      dsp_hreq <= 1'b0; hs_err <= 1'b0; rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      dsp_hreq <= dsp_hreq_in;
      rd_valid <= 1'b0;
      if ((st == S_LOW || st == S_HIGH) && dsp_hreq) seen <= 1'b1;
      if (st == S_IDLE) begin
        cnt <= '0;
        if (accept) begin
          tgt    <= req_tgt;
          half   <= (req_tgt == T_DEC || req_tgt == T_DSP) ? CW'(FAST_HALF) : CW'(SLOW_HALF);
          sh     <= frame;
          nb     <= (req_tgt == T_LED) ? 5'd15 : 5'd23;
          bitn   <= '0;
          seen   <= 1'b0;
          hs_err <= 1'b0;
          sel_n  <= sel_of;
          st     <= S_LEAD;
        end
      end else if (!tick) begin
        cnt <= cnt + CW'(1);
      end else begin
        cnt <= '0;
        case (st)
          S_LEAD: begin sclk <= 1'b0; st <= S_LOW; end
          S_LOW:  begin sclk <= 1'b1; rx <= {rx[22:0], sdi}; st <= S_HIGH; end
          S_HIGH:
            if (bitn == nb) st <= S_TAIL;
            else begin
              sclk <= 1'b0; sh <= {sh[22:0], 1'b0}; bitn <= bitn + 5'd1; st <= S_LOW;
            end
          S_TAIL: begin
            sel_n <= 4'hF;
            if (tgt == T_DEC) begin rd_data <= rx; rd_valid <= 1'b1; end
            if (tgt == T_DSP) hs_err <= !seen;
            if (tgt == T_LED || tgt == T_IR) begin
              lat <= (tgt == T_LED) ? 2'b01 : 2'b10;
              st  <= S_LATCH;
            end else st <= S_GAP;
          end
          S_LATCH: begin lat <= 2'b00; st <= S_GAP; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ser_ctl_master_chk.sv
module ser_ctl_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_tgt,
  input logic       busy,
  input logic       sclk,
  input logic       sdo,
  input logic [3:0] sel_n,
  input logic [1:0] lat,
  input logic       hs_err,
  input logic       rd_valid
);
  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && (&sel_n) && lat == 2'b00));

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n));

  a_r3_latch_released: assert property (@(posedge clk) disable iff (!rst_n)
    (|lat) |-> ((&sel_n) && sclk));

  a_r7_sdo_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && $past(busy)) |-> $stable(sdo));

  a_r7_sel_move_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_n) |-> sclk);

  a_r8_take_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_tgt < 3'd6) |=> busy);

  a_r10_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_tgt > 3'd5) |=> !busy);

  a_r5_rd_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(sel_n[2]));

  a_r6_flag_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_err) |-> $rose(sel_n[3]));
endmodule

bind ser_ctl_master ser_ctl_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tgt(req_tgt),
  .busy(busy), .sclk(sclk), .sdo(sdo), .sel_n(sel_n), .lat(lat),
  .hs_err(hs_err), .rd_valid(rd_valid)
);

// File: tb/ser_ctl_master_bench.sv
module ser_ctl_master_bench;
  localparam int SH = 4, FH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, sdi = 1'b0, hreq_in = 1'b0;
  logic [2:0] req_tgt = '0;
  logic [23:0] req_data = '0;
  logic busy, sclk, sdo, dsp_hreq, hs_err, rd_valid;
  logic [3:0] sel_n;
  logic [1:0] lat;
  logic [23:0] rd_data;

  ser_ctl_master #(.SLOW_HALF(SH), .FAST_HALF(FH)) u_ser_ctl_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tgt(req_tgt),
    .req_data(req_data), .busy(busy), .sclk(sclk), .sdo(sdo), .sdi(sdi),
    .sel_n(sel_n), .lat(lat), .dsp_hreq_in(hreq_in), .dsp_hreq(dsp_hreq),
    .hs_err(hs_err), .rd_data(rd_data), .rd_valid(rd_valid));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int mon_n, low_cnt, busy_cnt, lat_cnt, lat_at_n, rdv_cnt, dec_falls, dsp_rises;
  logic [23:0] mon_sh, dec_pat;
  logic [3:0] exp_sel;
  logic [1:0] lat_seen;
  logic sel_bad, hs_model;

  always @(posedge sclk) begin
    mon_sh = {mon_sh[22:0], sdo};
    mon_n++;
    if (sel_n !== exp_sel) sel_bad = 1'b1;
    if (!sel_n[3]) begin
      dsp_rises++;
      if (dsp_rises == 2 && hs_model) begin #1; hreq_in = 1'b1; end
    end
  end

  always @(posedge sel_n[3]) begin #16; hreq_in = 1'b0; end

  always @(negedge sclk) if (!sel_n[2]) begin
    if (dec_falls > 0) begin dec_pat = dec_pat << 1; #1; sdi = dec_pat[23]; end
    dec_falls++;
  end

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (!sclk) low_cnt++;
    if (|lat) begin
      if (lat_cnt == 0) lat_at_n = mon_n;
      lat_cnt++;
      lat_seen = lat_seen | lat;
    end
    if (rd_valid) rdv_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon(input logic [3:0] es);
    mon_n = 0; mon_sh = '0; low_cnt = 0; busy_cnt = 0; lat_cnt = 0; lat_at_n = -1;
    rdv_cnt = 0; dec_falls = 0; dsp_rises = 0; lat_seen = 2'b00; sel_bad = 1'b0; exp_sel = es;
  endtask

  task automatic issue(input logic [2:0] t, input logic [23:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_tgt = t; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 sclk idle", sclk, 1);
    chk("R1 selects idle", sel_n, 4'hF);
    chk("R1 latches idle", lat, 0);
    chk("R1 busy idle", busy, 0);
  endtask

  task automatic t_addr_frame(input logic [2:0] t, input logic [7:0] a, input logic [23:0] d, input logic [3:0] es, input string nm);
    clear_mon(es);
    issue(t, d);
    wait_idle();
    chk({"R2 frame ", nm}, mon_sh, {a, d[15:0]});
    chk({"R2 bit count ", nm}, mon_n, 24);
    chk({"R2 select held ", nm}, sel_bad, 0);
    chk({"R7 slow low time ", nm}, low_cnt, 24 * SH);
    chk({"R8 busy window ", nm}, busy_cnt, SH * 50 + 2 * SH);
  endtask

  task automatic t_latch_frame(input logic [2:0] t, input logic [23:0] d, input int n, input logic [1:0] which, input string rq);
    clear_mon(4'hF);
    issue(t, d);
    wait_idle();
    chk({rq, " frame"}, mon_sh & ((n == 16) ? 24'h00FFFF : 24'hFFFFFF), (n == 16) ? {8'h0, d[15:0]} : d);
    chk({rq, " bit count"}, mon_n, n);
    chk({rq, " latch line"}, lat_seen, which);
    chk({rq, " latch width"}, lat_cnt, 2 * SH);
    chk({rq, " latch after last bit"}, lat_at_n, n);
    chk("R8 busy window latch", busy_cnt, SH * (2 * n + 2) + 4 * SH);
  endtask

  task automatic t_decoder(input logic [23:0] d, input logic [23:0] back);
    clear_mon(4'b1011);
    dec_pat = back; sdi = back[23];
    issue(3'd4, d);
    wait_idle();
    chk("R5 frame out", mon_sh, d);
    chk("R5 read back", rd_data, back);
    chk("R5 read strobe", rdv_cnt, 1);
    chk("R7 fast low time", low_cnt, 24 * FH);
    chk("R5 select held", sel_bad, 0);
    chk("R8 busy window fast", busy_cnt, FH * 50 + 2 * FH);
  endtask

  task automatic t_dsp(input logic [23:0] d, input logic model, input logic exp_err);
    clear_mon(4'b0111);
    hs_model = model;
    issue(3'd5, d);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R6 frame out", mon_sh, d);
    chk("R6 handshake flag", hs_err, exp_err);
    chk("R6 no read strobe", rdv_cnt, 0);
  endtask

  task automatic t_hreq_mirror();
    @(negedge clk); hreq_in = 1'b1;
    @(negedge clk); chk("R6 hreq follows", dsp_hreq, 1);
    hreq_in = 1'b0;
    @(negedge clk); chk("R6 hreq follows low", dsp_hreq, 0);
  endtask

  task automatic t_refuse();
    clear_mon(4'b1110);
    issue(3'd0, 24'h00A5C3);
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_tgt = 3'd2; req_data = 24'hFFFFFF;
    @(negedge clk); req_valid = 1'b0;
    wait_idle();
    chk("R9 frame intact", mon_sh, 24'h17A5C3);
    chk("R9 no latch", lat_cnt, 0);
    chk("R9 busy window", busy_cnt, SH * 50 + 2 * SH);
    @(negedge clk);
    chk("R9 idle after", busy, 0);
  endtask

  task automatic t_bad_code(input logic [2:0] t);
    clear_mon(4'hF);
    issue(t, 24'h123456);
    repeat (3) @(negedge clk);
    chk("R10 busy stays low", busy, 0);
    chk("R10 selects idle", sel_n, 4'hF);
    chk("R10 no clocks", mon_n, 0);
    chk("R10 no latch", lat_cnt, 0);
  endtask

  initial begin
    hs_model = 1'b0;
    clear_mon(4'hF);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_addr_frame(3'd0, 8'h17, 24'hFF1234, 4'b1110, "receiver");
    t_addr_frame(3'd1, 8'h20, 24'h00BEEF, 4'b1101, "dac");
    t_latch_frame(3'd2, 24'h77A55A, 16, 2'b01, "R3");
    t_latch_frame(3'd3, 24'hC0FFEE, 24, 2'b10, "R4");
    t_decoder(24'h13579B, 24'hA5F00F);
    t_decoder(24'h800001, 24'h5AC3E1);
    t_hreq_mirror();
    t_dsp(24'h2468AC, 1'b1, 1'b0);
    t_dsp(24'hFEDCBA, 1'b0, 1'b1);
    t_dsp(24'h000001, 1'b1, 1'b0);
    t_refuse();
    t_bad_code(3'd6);
    t_bad_code(3'd7);
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule